// File: doc/BRIEF.md
# Region Protection Checker

This block screens every bus access against a set of programmable protection regions. Software programs each region through a small register-write port. A region has a base address, an enable, a power-of-two size code, a three-bit permission code, an execute-never bit and an eight-bit mask that disables slices of the region. A global control word turns checking on. It also selects whether checking continues inside the hard-fault/NMI handler, and whether privileged code falls back to the default memory map when no region matches.

For each access the block reports the address, the direction, whether the access is an instruction fetch and whether it is privileged. The block finds the highest-numbered enabled region that contains the address and applies that region's rights. The violation output is combinational. On a violation the fault status and the faulting address are latched at the next clock edge. They stay set until software clears them by writing ones.

Top module: `rgn_guard`

## Requirements
- R1: When control bit 0 (global enable) is clear, `acc_viol` stays low for every access.
- R2: When several enabled regions contain the address, the one with the highest index decides the outcome.
- R3: A region with size code S covers 2^(S+1) bytes and matches an address when the address bits above bit S agree with its base. Codes 0 to 3 never match. Code 31 covers the whole 4 GB space.
- R4: Attribute bits 23:16 split a region into eight equal slices, with bit 16 for the lowest slice. An address in a slice whose bit is set does not match that region.
- R5: Permission code (attribute bits 10:8) gives privileged/unprivileged rights as follows: 000 none/none, 001 RW/none, 010 RW/RO, 011 RW/RW, 101 RO/none, 110 RO/RO. Codes 100 and 111 deny everything. A fetch needs read rights, and a write needs RW.
- R6: When the deciding region has execute-never (attribute bit 12) set, any fetch that hits it is a violation, whatever the permission code.
- R7: An access that matches no region is a violation when it is unprivileged. When it is privileged, it is a violation only if control bit 2 (default map) is clear.
- R8: An access flagged as running in the hard-fault/NMI handler is never a violation while control bit 1 is clear.
- R9: A violation on a valid access sets status bit 0 (fetch) or bit 1 (data) at the next clock edge. It also sets bit 7 and captures the address in `flt_addr` if bit 7 was clear.
- R10: Status bits are sticky. While bit 7 stays set, later faults leave `flt_addr` unchanged.
- R11: A write with `cfg_sel`=3 clears the status bits that are 1 in `cfg_wdata`. A fault in the same cycle is applied after the clear. If bit 7 is cleared in that cycle, the new address is captured.
- R12: After reset, status, address and control are zero. `acc_viol` is low whenever `acc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | 0 region base, 1 region attributes, 2 control word, 3 status clear |
| cfg_idx | input | 3 | Region index for selections 0 and 1 |
| cfg_wdata | input | 32 | Write data. Attributes: bit 0 enable, 5:1 size, 10:8 permission, 12 execute-never, 23:16 slice mask. Control: bit 0 enable, 1 handler check, 2 default map |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_write | input | 1 | 1 write, 0 read |
| acc_fetch | input | 1 | Instruction fetch |
| acc_priv | input | 1 | Privileged access |
| acc_handler | input | 1 | Access issued from the hard-fault/NMI handler |
| acc_viol | output | 1 | Combinational violation flag |
| flt_status | output | 8 | Sticky fault status (bits 0, 1, 7) |
| flt_addr | output | 32 | Captured faulting address |

## Verification
A clear write from software and a new violation can land on the same clock edge. The result must show the clear applied first and the new fault layered on top. The bench provokes this by driving a status-clear write of bits 7 and 0 in the same cycle as a faulting fetch to a fresh address. It then expects status 0x83 with the new address captured, which shows that set wins over clear and that address capture reopens. The permission logic is judged separately by sweeping address windows over overlapping regions. Every combination of write, fetch, privilege and handler flag is compared against a bench model that uses division and modulo to find regions and slices.

// File: rtl/rgn_guard_pkg.sv
package rgn_guard_pkg;

  localparam int ADDR_W  = 32;
  localparam int SZ_W    = 5;
  localparam int AP_W    = 3;
  localparam int SUB_N   = 8;
  localparam int SUB_W   = $clog2(SUB_N);
  localparam int ST_W    = 8;
  localparam int MIN_SZ  = 4;

  // attribute word layout
  localparam int A_EN     = 0;
  localparam int A_SZ_LO  = 1;
  localparam int A_AP_LO  = 8;
  localparam int A_XN     = 12;
  localparam int A_SRD_LO = 16;

  // control word layout
  localparam int C_EN  = 0;
  localparam int C_HND = 1;
  localparam int C_DEF = 2;

  // status layout
  localparam int S_IACC  = 0;
  localparam int S_DACC  = 1;
  localparam int S_VALID = 7;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_ATTR = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_FCLR = 2'd3
  } cfg_sel_e;

  // address lies in the aligned block of 2^(sz+1) bytes that holds base
  function automatic logic rg_covers(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] b,
                                     input logic [SZ_W-1:0]   sz);
    logic [ADDR_W:0] lowm;
    lowm = ({{ADDR_W{1'b0}}, 1'b1} << ({1'b0, sz} + 6'd1)) - 1'b1;
    return ((a ^ b) & ~lowm[ADDR_W-1:0]) == '0;
  endfunction

  // slice index: the three bits just below the region size
  function automatic logic [SUB_W-1:0] rg_sub(input logic [ADDR_W-1:0] a,
                                              input logic [SZ_W-1:0]   sz);
    logic [ADDR_W-1:0] s;
    s = a >> (sz - 5'd2);
    return s[SUB_W-1:0];
  endfunction

  // rights check for one access against a permission code
  function automatic logic ap_allows(input logic [AP_W-1:0] ap,
                                     input logic priv,
                                     input logic wr);
    logic rd_ok, wr_ok;
    case (ap)
      3'b001:  begin rd_ok = priv;  wr_ok = priv;  end
      3'b010:  begin rd_ok = 1'b1;  wr_ok = priv;  end
      3'b011:  begin rd_ok = 1'b1;  wr_ok = 1'b1;  end
      3'b101:  begin rd_ok = priv;  wr_ok = 1'b0;  end
      3'b110:  begin rd_ok = 1'b1;  wr_ok = 1'b0;  end
      default: begin rd_ok = 1'b0;  wr_ok = 1'b0;  end
    endcase
    return wr ? wr_ok : rd_ok;
  endfunction

endpackage

// File: rtl/rgn_slot.sv
module rgn_slot
  import rgn_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_base,
  input  logic              wr_attr,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              en_in,
  input  logic [SZ_W-1:0]   sz_in,
  input  logic [AP_W-1:0]   ap_in,
  input  logic              xn_in,
  input  logic [SUB_N-1:0]  srd_in,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              hit,
  output logic [AP_W-1:0]   ap,
  output logic              xn
);

  logic [ADDR_W-1:0] base_q;
  logic              en_q;
  logic [SZ_W-1:0]   sz_q;
  logic [SUB_N-1:0]  srd_q;
  logic              in_block;
  logic              slice_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      en_q   <= 1'b0;
      sz_q   <= '0;
      ap     <= '0;
      xn     <= 1'b0;
      srd_q  <= '0;
    end else begin
      if (wr_base) base_q <= base_in;
      if (wr_attr) begin
        en_q  <= en_in;
        sz_q  <= sz_in;
        ap    <= ap_in;
        xn    <= xn_in;
        srd_q <= srd_in;
      end
    end
  end

  always_comb begin
    in_block  = rg_covers(acc_addr, base_q, sz_q);
    slice_off = srd_q[rg_sub(acc_addr, sz_q)];
    hit       = en_q && (sz_q >= SZ_W'(MIN_SZ)) && in_block && !slice_off;
  end

endmodule

// File: rtl/rgn_decide.sv
module rgn_decide
  import rgn_guard_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic                       acc_valid,
  input  logic                       acc_write,
  input  logic                       acc_fetch,
  input  logic                       acc_priv,
  input  logic                       acc_handler,
  input  logic                       ctl_en,
  input  logic                       ctl_hnd,
  input  logic                       ctl_def,
  input  logic [NREG-1:0]            hit_vec,
  input  logic [NREG-1:0][AP_W-1:0]  ap_vec,
  input  logic [NREG-1:0]            xn_vec,
  output logic                       any_hit,
  output logic [IDX_W-1:0]           win_idx,
  output logic                       win_xn,
  output logic                       chk_active,
  output logic                       viol
);

  logic deny;

  // later (higher) indices overwrite earlier ones
  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        win_idx = i[IDX_W-1:0];
      end
    end
  end

  always_comb begin
    win_xn     = xn_vec[win_idx];
    chk_active = ctl_en && !(acc_handler && !ctl_hnd);
    if (!any_hit)
      deny = !(acc_priv && ctl_def);
    else if (acc_fetch && win_xn)
      deny = 1'b1;
    else
      deny = !ap_allows(ap_vec[win_idx], acc_priv, acc_write);
    viol = acc_valid && chk_active && deny;
  end

endmodule

// File: rtl/rgn_fault.sv
module rgn_fault
  import rgn_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ST_W-1:0]   clr_mask,
  input  logic              set_ifetch,
  input  logic              set_data,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [ST_W-1:0]   flt_status,
  output logic [ADDR_W-1:0] flt_addr
);

  logic iacc_q, dacc_q, valid_q;
  logic iacc_n, dacc_n, valid_kept, capture;

  always_comb begin
    valid_kept = valid_q && !clr_mask[S_VALID];
    iacc_n     = (iacc_q && !clr_mask[S_IACC]) || set_ifetch;
    dacc_n     = (dacc_q && !clr_mask[S_DACC]) || set_data;
    capture    = (set_ifetch || set_data) && !valid_kept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iacc_q   <= 1'b0;
      dacc_q   <= 1'b0;
      valid_q  <= 1'b0;
      flt_addr <= '0;
    end else begin
      iacc_q  <= iacc_n;
      dacc_q  <= dacc_n;
      valid_q <= valid_kept || capture;
      if (capture) flt_addr <= acc_addr;
    end
  end

  always_comb begin
    flt_status          = '0;
    flt_status[S_IACC]  = iacc_q;
    flt_status[S_DACC]  = dacc_q;
    flt_status[S_VALID] = valid_q;
  end

endmodule

// File: rtl/rgn_guard.sv
module rgn_guard
  import rgn_guard_pkg::*;
#(
  parameter  int NREG  = 8,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [31:0]       cfg_wdata,
  input  logic              acc_valid,
  input  logic [31:0]       acc_addr,
  input  logic              acc_write,
  input  logic              acc_fetch,
  input  logic              acc_priv,
  input  logic              acc_handler,
  output logic              acc_viol,
  output logic [7:0]        flt_status,
  output logic [31:0]       flt_addr
);

  logic [2:0]               ctl_q;
  logic                     ctl_en, ctl_hnd, ctl_def;
  logic [NREG-1:0]          hit_vec;
  logic [NREG-1:0][AP_W-1:0] ap_vec;
  logic [NREG-1:0]          xn_vec;
  logic                     any_hit, win_xn, chk_active;
  logic [IDX_W-1:0]         win_idx;
  logic [ST_W-1:0]          clr_mask;
  logic                     flt_clr7;
  logic                     set_ifetch, set_data;
  logic                     wr_base_any, wr_attr_any;
  logic                     unused_bits;

  assign wr_base_any = cfg_we && (cfg_sel == SEL_BASE);
  assign wr_attr_any = cfg_we && (cfg_sel == SEL_ATTR);
  assign unused_bits = ^{cfg_wdata[31:24], cfg_wdata[15:13], cfg_wdata[11], cfg_wdata[7:6]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             ctl_q <= '0;
    else if (cfg_we && cfg_sel == SEL_CTRL) ctl_q <= cfg_wdata[2:0];
  end

  assign ctl_en  = ctl_q[C_EN];
  assign ctl_hnd = ctl_q[C_HND];
  assign ctl_def = ctl_q[C_DEF];

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    rgn_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_base  (wr_base_any && (cfg_idx == IDX_W'(g))),
      .wr_attr  (wr_attr_any && (cfg_idx == IDX_W'(g))),
      .base_in  (cfg_wdata),
      .en_in    (cfg_wdata[A_EN]),
      .sz_in    (cfg_wdata[A_SZ_LO +: SZ_W]),
      .ap_in    (cfg_wdata[A_AP_LO +: AP_W]),
      .xn_in    (cfg_wdata[A_XN]),
      .srd_in   (cfg_wdata[A_SRD_LO +: SUB_N]),
      .acc_addr (acc_addr),
      .hit      (hit_vec[g]),
      .ap       (ap_vec[g]),
      .xn       (xn_vec[g])
    );
  end

  rgn_decide #(.NREG(NREG), .IDX_W(IDX_W)) u_decide (
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_fetch   (acc_fetch),
    .acc_priv    (acc_priv),
    .acc_handler (acc_handler),
    .ctl_en      (ctl_en),
    .ctl_hnd     (ctl_hnd),
    .ctl_def     (ctl_def),
    .hit_vec     (hit_vec),
    .ap_vec      (ap_vec),
    .xn_vec      (xn_vec),
    .any_hit     (any_hit),
    .win_idx     (win_idx),
    .win_xn      (win_xn),
    .chk_active  (chk_active),
    .viol        (acc_viol)
  );

  assign clr_mask   = (cfg_we && cfg_sel == SEL_FCLR) ? cfg_wdata[ST_W-1:0] : '0;
  assign flt_clr7   = clr_mask[S_VALID];
  assign set_ifetch = acc_viol && acc_fetch;
  assign set_data   = acc_viol && !acc_fetch;

  rgn_fault u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_mask   (clr_mask),
    .set_ifetch (set_ifetch),
    .set_data   (set_data),
    .acc_addr   (acc_addr),
    .flt_status (flt_status),
    .flt_addr   (flt_addr)
  );

endmodule

// File: rtl/rgn_guard_chk.sv
module rgn_guard_chk #(
  parameter int NREG  = 8,
  parameter int IDX_W = $clog2(NREG)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             acc_fetch,
  input logic             acc_priv,
  input logic             acc_handler,
  input logic             acc_viol,
  input logic [7:0]       flt_status,
  input logic [31:0]      flt_addr,
  input logic             ctl_en,
  input logic             ctl_hnd,
  input logic             chk_active,
  input logic             any_hit,
  input logic [NREG-1:0]  hit_vec,
  input logic [IDX_W-1:0] win_idx,
  input logic             win_xn,
  input logic             flt_clr7
);

  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> !acc_viol);

  a_r2_highest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> ((hit_vec >> win_idx) == NREG'(1)));

  a_r6_xn_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && chk_active && any_hit && win_xn && acc_fetch) |-> acc_viol);

  a_r7_user_nohit: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && chk_active && !any_hit && !acc_priv) |-> acc_viol);

  a_r8_handler_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_handler && !ctl_hnd) |-> !acc_viol);

  a_r9_fetch_status: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_viol && acc_fetch) |=> (flt_status[0] && flt_status[7]));

  a_r9_data_status: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_viol && !acc_fetch) |=> (flt_status[1] && flt_status[7]));

  a_r10_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_status[7] && !flt_clr7) |=> $stable(flt_addr));

  a_r11_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_status[7]) |-> $past(acc_viol));

  a_r12_valid_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !acc_viol);

endmodule

bind rgn_guard rgn_guard_chk #(.NREG(NREG), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .acc_fetch   (acc_fetch),
  .acc_priv    (acc_priv),
  .acc_handler (acc_handler),
  .acc_viol    (acc_viol),
  .flt_status  (flt_status),
  .flt_addr    (flt_addr),
  .ctl_en      (ctl_en),
  .ctl_hnd     (ctl_hnd),
  .chk_active  (chk_active),
  .any_hit     (any_hit),
  .hit_vec     (hit_vec),
  .win_idx     (win_idx),
  .win_xn      (win_xn),
  .flt_clr7    (flt_clr7)
);

// File: tb/rgn_guard_tb.sv
`timescale 1ns/1ps
module rgn_guard_tb;

  localparam int NREG = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        acc_fetch = 1'b0;
  logic        acc_priv = 1'b0;
  logic        acc_handler = 1'b0;
  logic        acc_viol;
  logic [7:0]  flt_status;
  logic [31:0] flt_addr;

  int nvec = 0;
  int nerr = 0;

  // bench copy of the programmed state
  logic [31:0] m_base [NREG];
  logic        m_en   [NREG];
  logic [4:0]  m_sz   [NREG];
  logic [2:0]  m_ap   [NREG];
  logic        m_xn   [NREG];
  logic [7:0]  m_srd  [NREG];
  logic [2:0]  m_ctl;

  always #4 clk = ~clk;

  rgn_guard #(.NREG(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_write(acc_write), .acc_fetch(acc_fetch),
    .acc_priv(acc_priv), .acc_handler(acc_handler), .acc_viol(acc_viol),
    .flt_status(flt_status), .flt_addr(flt_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit m_hit(input int r, input logic [31:0] a);
    longint unsigned span, sub;
    if (!m_en[r] || m_sz[r] < 5'd4) return 0;
    span = 64'd1 << (m_sz[r] + 1);
    if ((64'(a) / span) != (64'(m_base[r]) / span)) return 0;
    sub = (64'(a) % span) / (span / 8);
    return !m_srd[r][sub];
  endfunction

  // rights: 0 none, 1 read only, 2 read-write
  function automatic bit m_viol(input logic [31:0] a, input bit wr, input bit fe,
                                input bit pr, input bit hd);
    int win;
    int pv, uv, have, need;
    if (!m_ctl[0]) return 0;
    if (hd && !m_ctl[1]) return 0;
    win = -1;
    for (int r = NREG - 1; r >= 0; r--) begin
      if (win < 0 && m_hit(r, a)) win = r;
    end
    if (win < 0) return !(pr && m_ctl[2]);
    if (fe && m_xn[win]) return 1;
    case (m_ap[win])
      3'd1: begin pv = 2; uv = 0; end
      3'd2: begin pv = 2; uv = 1; end
      3'd3: begin pv = 2; uv = 2; end
      3'd5: begin pv = 1; uv = 0; end
      3'd6: begin pv = 1; uv = 1; end
      default: begin pv = 0; uv = 0; end
    endcase
    have = pr ? pv : uv;
    need = wr ? 2 : 1;
    return have < need;
  endfunction

  task automatic cfg_write(input logic [1:0] sel, input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_base(input int r, input logic [31:0] b);
    m_base[r] = b;
    cfg_write(2'd0, 3'(r), b);
  endtask

  task automatic set_attr(input int r, input bit en, input logic [4:0] sz,
                          input logic [2:0] ap, input bit xn, input logic [7:0] srd);
    m_en[r] = en; m_sz[r] = sz; m_ap[r] = ap; m_xn[r] = xn; m_srd[r] = srd;
    cfg_write(2'd1, 3'(r), {8'hA5, srd, 3'b000, xn, 1'b0, ap, 2'b00, sz, en});
  endtask

  task automatic set_ctl(input logic [2:0] v);
    m_ctl = v;
    cfg_write(2'd2, 3'd0, {29'd0, v});
  endtask

  // one access per cycle, every flag combination
  task automatic sweep(input string tag, input longint lo, input longint hi, input longint step);
    for (longint a = lo; a <= hi; a += step) begin
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a[31:0];
        acc_write = c[0]; acc_fetch = c[1]; acc_priv = c[2]; acc_handler = c[3];
        #1;
        chk(tag, {31'd0, acc_viol},
            {31'd0, m_viol(a[31:0], c[0], c[1], c[2], c[3])});
      end
    end
    @(negedge clk);
    acc_valid = 1'b0; acc_handler = 1'b0;
  endtask

  // one access held across exactly one rising edge
  task automatic pulse_access(input logic [31:0] a, input bit wr, input bit fe, input bit pr);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_write = wr; acc_fetch = fe; acc_priv = pr;
    acc_handler = 1'b0;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    for (int r = 0; r < NREG; r++) begin
      m_base[r] = '0; m_en[r] = 0; m_sz[r] = '0; m_ap[r] = '0; m_xn[r] = 0; m_srd[r] = '0;
    end
    m_ctl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state
    chk("R12 status after reset", {24'd0, flt_status}, 32'h0);
    chk("R12 address after reset", flt_addr, 32'h0);
    acc_valid = 1'b1; acc_addr = 32'h9000_0000; acc_priv = 1'b0;
    #1;
    chk("R1 disabled after reset", {31'd0, acc_viol}, 32'h0);
    acc_valid = 1'b0;

    // R9 / R10 / R11: fault capture, stickiness, clear against new fault
    set_ctl(3'b001);
    @(negedge clk);
    acc_addr = 32'h8000_0040; acc_priv = 1'b0; acc_valid = 1'b0;
    #1;
    chk("R12 invalid access quiet", {31'd0, acc_viol}, 32'h0);
    @(negedge clk);
    chk("R12 invalid access leaves status", {24'd0, flt_status}, 32'h0);

    pulse_access(32'h8000_0010, 1'b0, 1'b1, 1'b0);
    chk("R9 fetch fault status", {24'd0, flt_status}, 32'h81);
    chk("R9 fault address", flt_addr, 32'h8000_0010);

    pulse_access(32'h8000_0020, 1'b1, 1'b0, 1'b0);
    chk("R10 data fault adds bit 1", {24'd0, flt_status}, 32'h83);
    chk("R10 address kept", flt_addr, 32'h8000_0010);

    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 32'h81;
    acc_valid = 1'b1; acc_addr = 32'h8000_0030; acc_write = 1'b0; acc_fetch = 1'b1; acc_priv = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
    chk("R11 clear and fault same cycle", {24'd0, flt_status}, 32'h83);
    chk("R11 new address captured", flt_addr, 32'h8000_0030);

    cfg_write(2'd3, 3'd0, 32'h02);
    chk("R11 partial clear", {24'd0, flt_status}, 32'h81);
    cfg_write(2'd3, 3'd0, 32'hFF);
    chk("R11 full clear", {24'd0, flt_status}, 32'h00);

    // overlapping region set
    set_base(0, 32'h0000_0000); set_attr(0, 1, 5'd13, 3'b011, 0, 8'h80);
    set_base(1, 32'h0000_1000); set_attr(1, 1, 5'd11, 3'b110, 1, 8'h00);
    set_base(2, 32'h0000_1800); set_attr(2, 1, 5'd7,  3'b001, 0, 8'h05);
    set_base(3, 32'h0000_2000); set_attr(3, 1, 5'd3,  3'b011, 0, 8'h00);
    set_base(4, 32'h0000_2400); set_attr(4, 1, 5'd9,  3'b100, 0, 8'h00);
    set_base(5, 32'h0000_2800); set_attr(5, 1, 5'd4,  3'b010, 0, 8'h00);
    set_base(6, 32'h0000_3000); set_attr(6, 0, 5'd8,  3'b101, 0, 8'h00);
    set_base(7, 32'h0000_3200); set_attr(7, 1, 5'd6,  3'b010, 1, 8'h00);

    // R2 R3 R4 R5 R6 R7 R8: handler bypassed, no default map
    set_ctl(3'b001);
    sweep("R2 R3 R4 R5 R6 R7 R8 sweep A", 0, 64'h3FFC, 4);
    // checking in handler, default map on
    set_ctl(3'b111);
    sweep("R2 R3 R4 R5 R6 R7 R8 sweep B", 0, 64'h3FF0, 16);
    // R1: global enable off
    set_ctl(3'b110);
    sweep("R1 sweep", 0, 64'h3FC0, 64);

    // R3: whole-space region with a disabled slice
    set_base(7, 32'h0000_0000); set_attr(7, 1, 5'd31, 3'b101, 0, 8'h40);
    set_ctl(3'b011);
    sweep("R3 R4 R5 R7 sweep D high", 64'hFFFF_F000, 64'hFFFF_FFF0, 16);
    sweep("R3 R4 R7 sweep D slice edge", 64'hBFFF_FF00, 64'hC000_00F0, 16);
    sweep("R2 R3 R5 sweep D low", 0, 64'h3FC0, 64);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule